// File: doc/BRIEF.md
# Two-Operand Arctangent Front End

This block is the entry stage of a single-precision arctangent-of-quotient unit. It takes a numerator operand `y` and a denominator operand `x`, both IEEE754 binary32, and settles every case that needs no arithmetic. A not-a-number, an infinity or a zero on either input is resolved here in a fixed order of precedence, and the block returns the finished answer: a rounded multiple of π/4, or zero, carrying the sign of `y`.

Ordinary finite operands cannot be finished here. For them the block emits a reduced task for a downstream divider and arctangent core. The task holds a numerator and a denominator, both with the sign cleared and the numerator never larger than the denominator. It also holds an offset selector of zero, π/2 or π, a flag that tells the core to negate its own result before the offset is added, and the sign to put on the final value. The final result is `sign * (offset + (negate ? -t : t))`, where `t = arctan(numerator/denominator)` lies in [0, π/4]. The offset add therefore never cancels significance.

One register stage sits between the input and the output. Both sides use a valid/ready handshake.

Top module: `atan2fe_top`

## Requirements
- R1: `inReady` is high exactly when the output register is empty or `outReady` is high. A pair offered while `inValid` and `inReady` are both high is captured at that clock edge and appears with `outValid` high in the following cycle. `outValid` is low out of reset.
- R2: While `outValid` is high and `outReady` is low, every output field holds its value and no new pair is captured.
- R3: If `x` is a NaN, the special result is `x` bit for bit. Otherwise, if `y` is a NaN, the special result is `y` bit for bit.
- R4: If `x` is +infinity and `y` is infinite, the result is π/4 (0x3F490FDB) with the sign bit of `y`. If `x` is +infinity and `y` is finite, the result is a zero with the sign bit of `y`.
- R5: If `x` is -infinity and `y` is infinite, the result is 3π/4 (0x4016CBE4) with the sign of `y`. If `x` is -infinity and `y` is finite, the result is π (0x40490FDB) with the sign of `y`.
- R6: If `x` is finite and `y` is infinite, the result is π/2 (0x3FC90FDB) with the sign of `y`.
- R7: If `x` is a zero of either sign and `y` is finite and nonzero (subnormals count as nonzero), the result is π/2 with the sign of `y`.
- R8: If `y` is a zero and `x` is finite, the result is a zero with the sign of `y` when the sign bit of `x` is 0. It is π with the sign of `y` when the sign bit of `x` is 1.
- R9: When both operands are finite and nonzero, `isSpecial` is 0 and `specialResult` is 0. `numer` holds the smaller and `denom` the larger of |y| and |x|, each with bit 31 cleared. The magnitudes are compared as unsigned values of bits 30:0. On a tie, `numer` is |y|.
- R10: On the finite path, `offsetCode` is 0 for zero, 1 for π/2 and 2 for π, and code 3 never appears. For x > 0 with no swap the pair (offset, negate) is (0,0). For x > 0 with a swap it is (1,1). For x < 0 with no swap it is (2,1). For x < 0 with a swap it is (1,0).
- R11: On the finite path, `resultSign` is the sign bit of `y`. On a special result, `isSpecial` is 1 and `numer`, `denom`, `offsetCode`, `negateCore` and `resultSign` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand pair offered |
| inReady | output | 1 | Block can take a pair this cycle |
| yIn | input | 32 | Numerator operand y, binary32 |
| xIn | input | 32 | Denominator operand x, binary32 |
| outValid | output | 1 | Output packet holds a result |
| outReady | input | 1 | Consumer takes the packet this cycle |
| isSpecial | output | 1 | Final answer is in specialResult |
| specialResult | output | 32 | Finished binary32 result for special cases |
| numer | output | 32 | Reduced numerator, sign cleared |
| denom | output | 32 | Reduced denominator, sign cleared |
| offsetCode | output | 2 | Offset added after the core: 0 none, 1 π/2, 2 π |
| negateCore | output | 1 | Core result is negated before the offset add |
| resultSign | output | 1 | Sign applied to the final finite-path value |

## Verification
The assertions assume that `inValid`, `yIn` and `xIn` are settled before each rising edge and are known after reset. They also assume the consumer follows the handshake, so a held packet is judged only by its own stability and not by whether the upstream keeps its offer. The bench changes every input on the falling edge and lowers `inValid` after each accepted pair. It covers the special cases with directed operand pairs. For the finite path it draws operands whose exponent field stays between 1 and 254, so no NaN, infinity or zero reaches the reduction checks by accident.

// File: rtl/atan2fe_pkg.sv
package atan2fe_pkg;

  localparam int FP_EXP_W = 8;
  localparam int FP_MAN_W = 23;
  localparam int FP_W     = 1 + FP_EXP_W + FP_MAN_W;

  // Binary32 constants, rounded to nearest even, sign bit clear.
  localparam logic [FP_W-1:0] K_QUARTER_PI = 32'h3F490FDB;
  localparam logic [FP_W-1:0] K_HALF_PI    = 32'h3FC90FDB;
  localparam logic [FP_W-1:0] K_3QTR_PI    = 32'h4016CBE4;
  localparam logic [FP_W-1:0] K_PI         = 32'h40490FDB;

  typedef enum logic [1:0] {
    OFS_ZERO    = 2'd0,
    OFS_HALF_PI = 2'd1,
    OFS_PI      = 2'd2
  } offsetSel_e;

  typedef struct packed {
    logic isNan;
    logic isInf;
    logic isZero;
    logic sign;
  } opClass_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;
    logic hold;
  } ctrlStrobe_t;

endpackage

// File: rtl/atan2fe_classify.sv
module atan2fe_classify
  import atan2fe_pkg::*;
#(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] op,
  output opClass_t     cls,
  output logic [W-2:0] mag
);

  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic             expAllOnes;
  logic             expAllZero;
  logic             manZero;

  assign expField   = op[W-2 -: EXP_W];
  assign manField   = op[MAN_W-1:0];
  assign expAllOnes = &expField;
  assign expAllZero = ~|expField;
  assign manZero    = ~|manField;

  assign cls.isNan  = expAllOnes & ~manZero;
  assign cls.isInf  = expAllOnes &  manZero;
  assign cls.isZero = expAllZero &  manZero;
  assign cls.sign   = op[W-1];
  assign mag        = op[W-2:0];

endmodule

// File: rtl/atan2fe_ctrl.sv
module atan2fe_ctrl
  import atan2fe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output ctrlStrobe_t strb
);

  logic validQ;

  assign inReady   = !validQ || outReady;
  assign strb.load = inValid && inReady;
  assign strb.hold = validQ && !outReady;
  assign outValid  = validQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validQ <= 1'b0;
    end else if (strb.load) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

  a_r1_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> outValid);

  a_r1_blocked_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |-> !inReady);

  a_r2_stays_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid);

endmodule

// File: rtl/atan2fe_datapath.sv
module atan2fe_datapath
  import atan2fe_pkg::*;
#(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  parameter logic [FP_W-1:0] QPI  = K_QUARTER_PI,
  parameter logic [FP_W-1:0] HPI  = K_HALF_PI,
  parameter logic [FP_W-1:0] TQPI = K_3QTR_PI,
  parameter logic [FP_W-1:0] FPI  = K_PI,
  localparam int W = 1 + EXP_W + MAN_W,
  localparam int N_OPS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctrlStrobe_t  strb,
  input  logic [W-1:0] yIn,
  input  logic [W-1:0] xIn,
  output logic         isSpecial,
  output logic [W-1:0] specialResult,
  output logic [W-1:0] numer,
  output logic [W-1:0] denom,
  output logic [1:0]   offsetCode,
  output logic         negateCore,
  output logic         resultSign
);

  logic [W-1:0] ops  [N_OPS];
  opClass_t     cls  [N_OPS];
  logic [W-2:0] mags [N_OPS];

  assign ops[0] = yIn;
  assign ops[1] = xIn;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    atan2fe_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op (ops[g]),
      .cls(cls[g]),
      .mag(mags[g])
    );
  end

  opClass_t cy, cx;
  assign cy = cls[0];
  assign cx = cls[1];

  function automatic logic [W-1:0] signedConst(input logic [W-1:0] c, input logic s);
    return {s, c[W-2:0]};
  endfunction

  logic         nSpecial;
  logic [W-1:0] nRes;
  logic [W-1:0] nNum;
  logic [W-1:0] nDen;
  offsetSel_e   nOfs;
  logic         nNeg;
  logic         nSign;
  logic         swapQ;

  assign swapQ = mags[0] > mags[1];

  always_comb begin
    nSpecial = 1'b1;
    nRes     = '0;
    nNum     = '0;
    nDen     = '0;
    nOfs     = OFS_ZERO;
    nNeg     = 1'b0;
    nSign    = 1'b0;
    if (cx.isNan) begin
      nRes = xIn;
    end else if (cy.isNan) begin
      nRes = yIn;
    end else if (cx.isInf && !cx.sign) begin
      nRes = signedConst(cy.isInf ? QPI : '0, cy.sign);
    end else if (cx.isInf) begin
      nRes = signedConst(cy.isInf ? TQPI : FPI, cy.sign);
    end else if (cy.isInf || (cx.isZero && !cy.isZero)) begin
      nRes = signedConst(HPI, cy.sign);
    end else if (cy.isZero) begin
      nRes = signedConst(cx.sign ? FPI : '0, cy.sign);
    end else begin
      nSpecial = 1'b0;
      nNum     = {1'b0, swapQ ? mags[1] : mags[0]};
      nDen     = {1'b0, swapQ ? mags[0] : mags[1]};
      nSign    = cy.sign;
      unique case ({cx.sign, swapQ})
        2'b00: begin nOfs = OFS_ZERO;    nNeg = 1'b0; end
        2'b01: begin nOfs = OFS_HALF_PI; nNeg = 1'b1; end
        2'b10: begin nOfs = OFS_PI;      nNeg = 1'b1; end
        default: begin nOfs = OFS_HALF_PI; nNeg = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isSpecial     <= 1'b0;
      specialResult <= '0;
      numer         <= '0;
      denom         <= '0;
      offsetCode    <= OFS_ZERO;
      negateCore    <= 1'b0;
      resultSign    <= 1'b0;
    end else if (strb.load) begin
      isSpecial     <= nSpecial;
      specialResult <= nRes;
      numer         <= nNum;
      denom         <= nDen;
      offsetCode    <= nOfs;
      negateCore    <= nNeg;
      resultSign    <= nSign;
    end
  end

  a_r2_packet_held: assert property (@(posedge clk) disable iff (!rst_n)
    strb.hold |=> ($stable(isSpecial) && $stable(specialResult) && $stable(numer)
                   && $stable(denom) && $stable(offsetCode) && $stable(negateCore)
                   && $stable(resultSign)));

  a_r3_nan_x_first: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && cx.isNan) |=> (isSpecial && specialResult == $past(xIn)));

endmodule

// File: rtl/atan2fe_top.sv
module atan2fe_top
  import atan2fe_pkg::*;
#(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  output logic         inReady,
  input  logic [W-1:0] yIn,
  input  logic [W-1:0] xIn,
  output logic         outValid,
  input  logic         outReady,
  output logic         isSpecial,
  output logic [W-1:0] specialResult,
  output logic [W-1:0] numer,
  output logic [W-1:0] denom,
  output logic [1:0]   offsetCode,
  output logic         negateCore,
  output logic         resultSign
);

  ctrlStrobe_t strb;

  atan2fe_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strb    (strb)
  );

  atan2fe_datapath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .yIn          (yIn),
    .xIn          (xIn),
    .isSpecial    (isSpecial),
    .specialResult(specialResult),
    .numer        (numer),
    .denom        (denom),
    .offsetCode   (offsetCode),
    .negateCore   (negateCore),
    .resultSign   (resultSign)
  );

  a_r10_offset_legal: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (offsetCode != 2'b11));

  a_r9_ratio_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !isSpecial) |-> (!numer[W-1] && !denom[W-1] && numer[W-2:0] <= denom[W-2:0]));

  a_r11_special_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && isSpecial) |-> (numer == '0 && denom == '0 && offsetCode == 2'd0
                                 && !negateCore && !resultSign));

endmodule

// File: tb/atan2fe_top_tb.sv
module atan2fe_top_tb;

  localparam int NV = 28;
  localparam int NRAND = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        outReady = 1'b1;
  logic [31:0] yIn = '0;
  logic [31:0] xIn = '0;
  logic        inReady, outValid, isSpecial, negateCore, resultSign;
  logic [31:0] specialResult, numer, denom;
  logic [1:0]  offsetCode;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  atan2fe_top u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .yIn(yIn), .xIn(xIn), .outValid(outValid), .outReady(outReady),
    .isSpecial(isSpecial), .specialResult(specialResult), .numer(numer),
    .denom(denom), .offsetCode(offsetCode), .negateCore(negateCore),
    .resultSign(resultSign)
  );

  // Row: {y, x, isSpecial, specialResult, numer, denom, offset, negate, sign}
  localparam logic [164:0] VEC [NV] = '{
    // R3
    {32'h3F800000, 32'h7FC00001, 1'b1, 32'h7FC00001, 64'h0, 4'h0},
    {32'h7FA00000, 32'hFFC00000, 1'b1, 32'hFFC00000, 64'h0, 4'h0},
    {32'h7FC12345, 32'h3F800000, 1'b1, 32'h7FC12345, 64'h0, 4'h0},
    // R4
    {32'h7F800000, 32'h7F800000, 1'b1, 32'h3F490FDB, 64'h0, 4'h0},
    {32'hFF800000, 32'h7F800000, 1'b1, 32'hBF490FDB, 64'h0, 4'h0},
    {32'hBF800000, 32'h7F800000, 1'b1, 32'h80000000, 64'h0, 4'h0},
    {32'h00000000, 32'h7F800000, 1'b1, 32'h00000000, 64'h0, 4'h0},
    // R5
    {32'h7F800000, 32'hFF800000, 1'b1, 32'h4016CBE4, 64'h0, 4'h0},
    {32'hFF800000, 32'hFF800000, 1'b1, 32'hC016CBE4, 64'h0, 4'h0},
    {32'h40000000, 32'hFF800000, 1'b1, 32'h40490FDB, 64'h0, 4'h0},
    {32'h80000000, 32'hFF800000, 1'b1, 32'hC0490FDB, 64'h0, 4'h0},
    // R6
    {32'hFF800000, 32'h40400000, 1'b1, 32'hBFC90FDB, 64'h0, 4'h0},
    {32'h7F800000, 32'h00000000, 1'b1, 32'h3FC90FDB, 64'h0, 4'h0},
    // R7
    {32'hC0A00000, 32'h00000000, 1'b1, 32'hBFC90FDB, 64'h0, 4'h0},
    {32'h3F800000, 32'h80000000, 1'b1, 32'h3FC90FDB, 64'h0, 4'h0},
    {32'h00000001, 32'h00000000, 1'b1, 32'h3FC90FDB, 64'h0, 4'h0},
    // R8
    {32'h00000000, 32'h00000000, 1'b1, 32'h00000000, 64'h0, 4'h0},
    {32'h80000000, 32'h00000000, 1'b1, 32'h80000000, 64'h0, 4'h0},
    {32'h00000000, 32'h80000000, 1'b1, 32'h40490FDB, 64'h0, 4'h0},
    {32'h80000000, 32'h80000000, 1'b1, 32'hC0490FDB, 64'h0, 4'h0},
    {32'h80000000, 32'hC0E00000, 1'b1, 32'hC0490FDB, 64'h0, 4'h0},
    {32'h00000000, 32'h40E00000, 1'b1, 32'h00000000, 64'h0, 4'h0},
    // R9 R10 R11 finite path
    {32'h3F800000, 32'h40000000, 1'b0, 32'h0, 32'h3F800000, 32'h40000000, 2'd0, 1'b0, 1'b0},
    {32'hC0000000, 32'h3F800000, 1'b0, 32'h0, 32'h3F800000, 32'h40000000, 2'd1, 1'b1, 1'b1},
    {32'h3F800000, 32'hC0000000, 1'b0, 32'h0, 32'h3F800000, 32'h40000000, 2'd2, 1'b1, 1'b0},
    {32'hC0000000, 32'hBF800000, 1'b0, 32'h0, 32'h3F800000, 32'h40000000, 2'd1, 1'b0, 1'b1},
    {32'hBF800000, 32'hBF800000, 1'b0, 32'h0, 32'h3F800000, 32'h3F800000, 2'd2, 1'b1, 1'b1},
    {32'h3F800000, 32'h00000001, 1'b0, 32'h0, 32'h00000001, 32'h3F800000, 2'd1, 1'b1, 1'b0}
  };

  function automatic logic [100:0] outPkt();
    return {isSpecial, specialResult, numer, denom, offsetCode, negateCore, resultSign};
  endfunction

  // Reference for the finite path (R9, R10, R11), written from the requirements.
  function automatic logic [100:0] finiteRef(logic [31:0] y, logic [31:0] x);
    logic [30:0] ay = y[30:0];
    logic [30:0] ax = x[30:0];
    logic big = ay > ax;
    logic [1:0] ofs;
    logic neg;
    if (!x[31]) begin ofs = big ? 2'd1 : 2'd0; neg = big; end
    else        begin ofs = big ? 2'd1 : 2'd2; neg = !big; end
    return {1'b0, 32'h0, {1'b0, big ? ax : ay}, {1'b0, big ? ay : ax}, ofs, neg, y[31]};
  endfunction

  task automatic check(string tag, logic [100:0] act, logic [100:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic sendOne(logic [31:0] y, logic [31:0] x);
    @(negedge clk);
    yIn = y; xIn = x; inValid = 1'b1; outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  function automatic logic [31:0] finiteOperand(logic [31:0] r);
    logic [7:0] e = 8'((r[30:23] % 8'd254) + 8'd1);
    return {r[31], e, r[22:0]};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] lfsr = 32'h1D872B41;
    logic [31:0] ry, rx;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset outValid", {100'h0, outValid}, 101'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle inReady", {100'h0, inReady}, 101'h1);

    // Table walk: R3..R11
    for (int i = 0; i < NV; i++) begin
      sendOne(VEC[i][164:133], VEC[i][132:101]);
      check($sformatf("R1 row %0d valid", i), {100'h0, outValid}, 101'h1);
      check($sformatf("R3-R11 row %0d", i), outPkt(), VEC[i][100:0]);
    end

    // Random finite pairs against the reference: R9, R10
    for (int k = 0; k < NRAND; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ry = finiteOperand(lfsr ^ 32'h5A5A1234);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rx = finiteOperand({lfsr[15:0], lfsr[31:16]});
      if (k % 7 == 0) rx = {~rx[31], ry[30:0]};  // tie magnitudes
      sendOne(ry, rx);
      check("R9 R10 random finite", outPkt(), finiteRef(ry, rx));
    end

    // R2: backpressure holds the packet and blocks input
    @(negedge clk);
    outReady = 1'b0;
    yIn = 32'h7F800000; xIn = 32'h7F800000; inValid = 1'b1;
    @(negedge clk);
    yIn = 32'h80000000; xIn = 32'h80000000;
    check("R1 full blocks inReady", {100'h0, inReady}, 101'h0);
    @(negedge clk);
    check("R2 held packet", outPkt(), {1'b1, 32'h3F490FDB, 68'h0});
    check("R2 held valid", {100'h0, outValid}, 101'h1);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R2 next after release", outPkt(), {1'b1, 32'hC0490FDB, 68'h0});
    @(negedge clk);
    check("R1 drained", {100'h0, outValid}, 101'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule